// File: doc/BRIEF.md
# I2C Write-Only Slave with 10-Bit Addressing

This block sits on a two-wire bus as a slave that only accepts data. A master writes to it using a ten-bit address. The block samples the clock and data lines into a fast system clock domain. It finds bus START and STOP conditions. It matches the address, which arrives in two bytes, against a ten-bit value that software programs. It acknowledges by pulling the data line low.

Once the address has matched, every byte the master sends is shifted in and placed in a receive register. For each byte the block answers ACK or NACK according to a software refuse bit. The current value of that bit is used at the moment the byte completes.

Software sees a small status word and an interrupt line. The status word holds an address-hit flag, a transfer-direction flag, a byte-ready flag and an overrun flag. A one-cycle status-read strobe clears the address-hit and overrun flags. A one-cycle data-read strobe clears the byte-ready flag. A general-call enable lets the block also accept the all-zero broadcast address.

Top module: `i2c10_slave_rx`

## Requirements
- R1: After reset `sda_oe`, `irq`, `stat_addr_match`, `stat_dir`, `stat_rx_ready` and `stat_overrun` are all 0.
- R2: After a START, a first byte equal to binary 11110, then `cfg_addr[9]`, `cfg_addr[8]`, then a 0 write bit (sent MSB first), is acknowledged on the ninth clock. A first byte that differs from this (wrong prefix, wrong high bits, or write bit 1) gets a NACK. The slave then stays idle until the next START.
- R3: If the second byte equals `cfg_addr[7:0]`, it is acknowledged, `stat_addr_match` becomes 1, `stat_dir` reads 0 (write) and `irq` goes high. If it differs, it gets a NACK and no flag is set.
- R4: A one-cycle `stat_rd` pulse clears `stat_addr_match` and `stat_overrun`.
- R5: After an address match, a data byte gets an ACK when `cfg_nak` is 0 and a NACK when it is 1. In both cases the byte is delivered.
- R6: After each data byte, `rx_data` holds the byte (first bit received in bit 7), `stat_rx_ready` becomes 1 and `irq` goes high. A one-cycle `data_rd` pulse clears `stat_rx_ready`.
- R7: If a byte arrives while `stat_rx_ready` is still 1, `stat_overrun` becomes 1 and `rx_data` takes the new byte.
- R8: While `cfg_enable` is 0 the slave never pulls SDA low and ignores the bus.
- R9: With `cfg_gcall_en` at 1, a first byte of 0x00 is acknowledged, sets `stat_addr_match`, and data bytes follow directly. With `cfg_gcall_en` at 0, 0x00 gets a NACK.
- R10: A repeated START restarts the address phase, so a following non-address byte gets a NACK. After a STOP, bytes clocked without a START get a NACK.
- R11: SDA is released at the falling SCL edge that ends each acknowledge bit, and `sda_oe` is never 1 outside an acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| scl_in | input | 1 | bus clock line level |
| sda_in | input | 1 | bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| cfg_enable | input | 1 | slave takes part on the bus |
| cfg_gcall_en | input | 1 | accept the general-call byte 0x00 |
| cfg_addr | input | 10 | programmed ten-bit slave address |
| cfg_nak | input | 1 | answer data bytes with NACK |
| stat_rd | input | 1 | status-read strobe |
| data_rd | input | 1 | receive-data read strobe |
| stat_addr_match | output | 1 | address-hit flag |
| stat_dir | output | 1 | direction flag, 0 = master writes |
| stat_rx_ready | output | 1 | byte waiting in `rx_data` |
| stat_overrun | output | 1 | byte overwritten before being read |
| rx_data | output | 8 | last received data byte |
| irq | output | 1 | OR of address-hit, byte-ready and overrun |

## Verification
The address path is driven with a correct pair of bytes and with single-fault variants. One variant has a wrong prefix, one has wrong high bits, one sets the read bit, and one has a wrong low byte. These show which part of each byte the match depends on, and that a failed first byte silences the second.

Data patterns with mixed bit values (0xA5, 0x3C, 0x81, 0x42) are sent under three conditions: refuse bit clear, refuse bit set, and reads held off. These separate the acknowledge choice from the delivery of the byte, and a plain overwrite from an overrun. Repeated START, STOP followed by clocking without a START, general call, and the disabled state then check that the bus framing and the configuration gate the engine.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_HI,
        ST_ACK_HI,
        ST_ADDR_LO,
        ST_ACK_LO,
        ST_DATA,
        ST_ACK_DATA
    } bus_state_e;
endpackage

// File: rtl/i2c10_sync.sv
module i2c10_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_level,
    output logic sda_level,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int NLINES = 2;

    typedef struct packed {
        logic [NLINES-1:0][STAGES-1:0] chain;
        logic [NLINES-1:0]             prev;
    } sync_t;

    sync_t q, d;
    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] lvl;

    assign raw = {sda_in, scl_in};

    genvar g;
    generate
        for (g = 0; g < NLINES; g++) begin : g_line
            assign lvl[g] = q.chain[g][STAGES-1];
        end
    endgenerate

    always_comb begin
        d = q;
        for (int i = 0; i < NLINES; i++) begin
            d.chain[i] = {q.chain[i][STAGES-2:0], raw[i]};
            d.prev[i]  = lvl[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_level = lvl[0];
    assign sda_level = lvl[1];
    assign scl_rise  = lvl[0] & ~q.prev[0];
    assign scl_fall  = ~lvl[0] & q.prev[0];
    assign start_evt = lvl[0] & q.prev[0] & q.prev[1] & ~lvl[1];
    assign stop_evt  = lvl[0] & q.prev[0] & ~q.prev[1] & lvl[1];
endmodule

// File: rtl/i2c10_bus_fsm.sv
module i2c10_bus_fsm
    import i2c10_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                gcall_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                nak,
    input  logic                sda_level,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_evt,
    input  logic                stop_evt,
    output logic                sda_oe,
    output logic                addr_hit,
    output logic                rx_valid,
    output logic [BYTE_W-1:0]   rx_byte
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    typedef struct packed {
        bus_state_e         state;
        logic [CNT_W-1:0]   bitcnt;
        logic [BYTE_W-1:0]  shreg;
        logic               oe;
        logic               to_data;
    } fsm_t;

    fsm_t q, d;
    logic [BYTE_W-1:0] hi_pattern;

    assign hi_pattern = {TEN_BIT_PREFIX, addr[ADDR_W-1:BYTE_W], 1'b0};

    always_comb begin
        d        = q;
        addr_hit = 1'b0;
        rx_valid = 1'b0;
        if (!enable) begin
            d.state  = ST_IDLE;
            d.oe     = 1'b0;
            d.bitcnt = '0;
        end else if (start_evt) begin
            d.state   = ST_ADDR_HI;
            d.oe      = 1'b0;
            d.bitcnt  = '0;
            d.to_data = 1'b0;
        end else if (stop_evt) begin
            d.state  = ST_IDLE;
            d.oe     = 1'b0;
            d.bitcnt = '0;
        end else begin
            unique case (q.state)
                ST_ADDR_HI, ST_ADDR_LO, ST_DATA: begin
                    if (scl_rise && q.bitcnt != FULL) begin
                        d.shreg  = {q.shreg[BYTE_W-2:0], sda_level};
                        d.bitcnt = q.bitcnt + CNT_W'(1);
                    end else if (scl_fall && q.bitcnt == FULL) begin
                        d.bitcnt = '0;
                        if (q.state == ST_ADDR_HI) begin
                            if (q.shreg == hi_pattern) begin
                                d.state   = ST_ACK_HI;
                                d.oe      = 1'b1;
                                d.to_data = 1'b0;
                            end else if (gcall_en && q.shreg == '0) begin
                                d.state   = ST_ACK_HI;
                                d.oe      = 1'b1;
                                d.to_data = 1'b1;
                                addr_hit  = 1'b1;
                            end else begin
                                d.state = ST_IDLE;
                            end
                        end else if (q.state == ST_ADDR_LO) begin
                            if (q.shreg == addr[BYTE_W-1:0]) begin
                                d.state  = ST_ACK_LO;
                                d.oe     = 1'b1;
                                addr_hit = 1'b1;
                            end else begin
                                d.state = ST_IDLE;
                            end
                        end else begin
                            rx_valid = 1'b1;
                            d.state  = ST_ACK_DATA;
                            d.oe     = ~nak;
                        end
                    end
                end
                ST_ACK_HI, ST_ACK_LO, ST_ACK_DATA: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        if (q.state == ST_ACK_HI && !q.to_data) d.state = ST_ADDR_LO;
                        else                                    d.state = ST_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= ST_IDLE;
            q.bitcnt  <= '0;
            q.shreg   <= '0;
            q.oe      <= 1'b0;
            q.to_data <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign rx_byte = q.shreg;

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sda_oe);
    // R11
    drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));
    // R11
    release_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> $past(scl_fall || start_evt || stop_evt || !enable));
    // R10
    stop_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && enable) |=> (q.state == ST_IDLE));
endmodule

// File: rtl/i2c10_flags.sv
module i2c10_flags
    import i2c10_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_hit,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              stat_rd,
    input  logic              data_rd,
    output logic              addr_match,
    output logic              dir,
    output logic              rx_ready,
    output logic              overrun,
    output logic [BYTE_W-1:0] data,
    output logic              irq
);
    typedef struct packed {
        logic              addr_match;
        logic              dir;
        logic              rx_ready;
        logic              overrun;
        logic [BYTE_W-1:0] data;
    } flags_t;

    flags_t q, d;

    always_comb begin
        d = q;
        if (addr_hit)     d.addr_match = 1'b1;
        else if (stat_rd) d.addr_match = 1'b0;
        if (addr_hit)     d.dir = 1'b0;
        if (rx_valid)     d.rx_ready = 1'b1;
        else if (data_rd) d.rx_ready = 1'b0;
        if (rx_valid && q.rx_ready && !data_rd) d.overrun = 1'b1;
        else if (stat_rd)                       d.overrun = 1'b0;
        if (rx_valid)     d.data = rx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign addr_match = q.addr_match;
    assign dir        = q.dir;
    assign rx_ready   = q.rx_ready;
    assign overrun    = q.overrun;
    assign data       = q.data;
    assign irq        = q.addr_match | q.rx_ready | q.overrun;

    // R3
    hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |=> addr_match);
    // R4
    read_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !addr_hit) |=> !addr_match);
    // R6
    byte_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (rx_ready && data == $past(rx_byte)));
    // R7
    overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !data_rd) |=> overrun);
endmodule

// File: rtl/i2c10_slave_rx.sv
module i2c10_slave_rx
    import i2c10_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              cfg_enable,
    input  logic              cfg_gcall_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_nak,
    input  logic              stat_rd,
    input  logic              data_rd,
    output logic              stat_addr_match,
    output logic              stat_dir,
    output logic              stat_rx_ready,
    output logic              stat_overrun,
    output logic [BYTE_W-1:0] rx_data,
    output logic              irq
);
    logic scl_level, sda_level, scl_rise, scl_fall, start_evt, stop_evt;
    logic addr_hit, rx_valid;
    logic [BYTE_W-1:0] rx_byte;

    i2c10_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_level (scl_level),
        .sda_level (sda_level),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c10_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_enable),
        .gcall_en  (cfg_gcall_en),
        .addr      (cfg_addr),
        .nak       (cfg_nak),
        .sda_level (sda_level),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_oe    (sda_oe),
        .addr_hit  (addr_hit),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte)
    );

    i2c10_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_hit   (addr_hit),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .stat_rd    (stat_rd),
        .data_rd    (data_rd),
        .addr_match (stat_addr_match),
        .dir        (stat_dir),
        .rx_ready   (stat_rx_ready),
        .overrun    (stat_overrun),
        .data       (rx_data),
        .irq        (irq)
    );

    // R11
    oe_only_when_scl_low_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_level);
endmodule

// File: tb/tb_i2c10_slave_rx.sv
module tb_i2c10_slave_rx;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe;
    logic cfg_enable = 1'b1, cfg_gcall_en = 1'b0, cfg_nak = 1'b0;
    logic [9:0] cfg_addr = 10'h2B6;
    logic stat_rd = 1'b0, data_rd = 1'b0;
    logic stat_addr_match, stat_dir, stat_rx_ready, stat_overrun, irq;
    logic [7:0] rx_data;
    logic sda_line;

    int compared = 0, mismatched = 0;
    bit done = 1'b0;
    bit drain_en = 1'b1;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c10_slave_rx dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .cfg_enable(cfg_enable), .cfg_gcall_en(cfg_gcall_en), .cfg_addr(cfg_addr),
        .cfg_nak(cfg_nak), .stat_rd(stat_rd), .data_rd(data_rd),
        .stat_addr_match(stat_addr_match), .stat_dir(stat_dir),
        .stat_rx_ready(stat_rx_ready), .stat_overrun(stat_overrun),
        .rx_data(rx_data), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wq(input int n = Q);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    // sends one byte MSB first, returns 1 when the slave acknowledged
    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        acked = !sda_line;
        wq(); scl_m = 1'b0; wq();
        // R11: released after the falling edge ending the acknowledge bit
        check(sda_oe == 1'b0, "R11", "sda released", sda_oe, 0);
    endtask

    task automatic put(input logic [7:0] b, input bit exp_ack, input bit deliver, input string req);
        bit a;
        if (deliver) exp_q.push_back(b);
        send_byte(b, a);
        check(a == exp_ack, req, "ack", a, exp_ack);
    endtask

    task automatic pulse_stat;
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
    endtask

    task automatic open_link;
        bus_start();
        put(8'hF4, 1'b1, 1'b0, "R2");
        put(8'hB6, 1'b1, 1'b0, "R3");
        pulse_stat();
    endtask

    // scoreboard monitor: pops the expected byte whenever one is ready
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && drain_en && stat_rx_ready && !data_rd) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected byte", rx_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rx_data == e, "R6", "rx_data", rx_data, e);
                end
                data_rd = 1'b1;
            end else begin
                data_rd = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        wq(5);
        // R1 reset state
        check({sda_oe, irq, stat_addr_match, stat_dir, stat_rx_ready, stat_overrun} == 6'b0,
              "R1", "reset outputs",
              {sda_oe, irq, stat_addr_match, stat_dir, stat_rx_ready, stat_overrun}, 0);
        rst_n = 1'b1;
        wq(5);
        check(irq == 1'b0, "R1", "irq after reset", irq, 0);

        // R2 R3 R5 R6 basic write
        bus_start();
        put(8'hF4, 1'b1, 1'b0, "R2");
        put(8'hB6, 1'b1, 1'b0, "R3");
        check(stat_addr_match == 1'b1, "R3", "addr match", stat_addr_match, 1);
        check(stat_dir == 1'b0, "R3", "dir write", stat_dir, 0);
        check(irq == 1'b1, "R3", "irq", irq, 1);
        pulse_stat();
        check(stat_addr_match == 1'b0, "R4", "match cleared", stat_addr_match, 0);
        check(irq == 1'b0, "R4", "irq cleared", irq, 0);
        put(8'hA5, 1'b1, 1'b1, "R5");
        put(8'h3C, 1'b1, 1'b1, "R5");
        bus_stop();
        wq();
        check(exp_q.size() == 0, "R6", "queue drained", exp_q.size(), 0);
        check(stat_rx_ready == 1'b0, "R6", "ready cleared by read", stat_rx_ready, 0);

        // R5 refuse bit
        open_link();
        cfg_nak = 1'b1;
        put(8'h5A, 1'b0, 1'b1, "R5");
        bus_stop();
        cfg_nak = 1'b0;
        wq();

        // R2 read bit, wrong high bits, wrong prefix
        bus_start();
        put(8'hF5, 1'b0, 1'b0, "R2");
        put(8'hB6, 1'b0, 1'b0, "R2");
        bus_stop();
        bus_start();
        put(8'hF6, 1'b0, 1'b0, "R2");
        bus_stop();
        bus_start();
        put(8'hE4, 1'b0, 1'b0, "R2");
        bus_stop();
        check(stat_addr_match == 1'b0, "R2", "no match flag", stat_addr_match, 0);

        // R3 wrong low byte
        bus_start();
        put(8'hF4, 1'b1, 1'b0, "R2");
        put(8'hB7, 1'b0, 1'b0, "R3");
        put(8'h11, 1'b0, 1'b0, "R3");
        bus_stop();
        check(stat_addr_match == 1'b0, "R3", "no match on low miss", stat_addr_match, 0);
        check(stat_rx_ready == 1'b0, "R3", "no byte after miss", stat_rx_ready, 0);

        // R7 overrun
        open_link();
        drain_en = 1'b0;
        put(8'h81, 1'b1, 1'b0, "R7");
        put(8'h42, 1'b1, 1'b0, "R7");
        bus_stop();
        check(stat_rx_ready == 1'b1, "R7", "ready held", stat_rx_ready, 1);
        check(stat_overrun == 1'b1, "R7", "overrun", stat_overrun, 1);
        check(rx_data == 8'h42, "R7", "newest byte", rx_data, 8'h42);
        exp_q.push_back(8'h42);
        drain_en = 1'b1;
        wq(5);
        check(stat_rx_ready == 1'b0, "R6", "ready cleared", stat_rx_ready, 0);
        check(stat_overrun == 1'b1, "R4", "overrun kept until status read", stat_overrun, 1);
        pulse_stat();
        check(stat_overrun == 1'b0, "R4", "overrun cleared", stat_overrun, 0);

        // R10 repeated START
        open_link();
        put(8'h99, 1'b1, 1'b1, "R10");
        bus_start();
        put(8'h77, 1'b0, 1'b0, "R10");
        bus_start();
        put(8'hF4, 1'b1, 1'b0, "R10");
        put(8'hB6, 1'b1, 1'b0, "R10");
        put(8'h66, 1'b1, 1'b1, "R10");
        bus_stop();
        pulse_stat();

        // R10 clocking after STOP without START
        scl_m = 1'b0; wq();
        put(8'hF4, 1'b0, 1'b0, "R10");
        bus_stop();

        // R9 general call
        cfg_gcall_en = 1'b1;
        bus_start();
        put(8'h00, 1'b1, 1'b0, "R9");
        check(stat_addr_match == 1'b1, "R9", "gcall match", stat_addr_match, 1);
        put(8'h12, 1'b1, 1'b1, "R9");
        bus_stop();
        pulse_stat();
        cfg_gcall_en = 1'b0;
        bus_start();
        put(8'h00, 1'b0, 1'b0, "R9");
        bus_stop();

        // R8 disabled
        cfg_enable = 1'b0;
        bus_start();
        put(8'hF4, 1'b0, 1'b0, "R8");
        put(8'hB6, 1'b0, 1'b0, "R8");
        bus_stop();
        check(stat_addr_match == 1'b0, "R8", "no match when disabled", stat_addr_match, 0);
        cfg_enable = 1'b1;

        wq(20);
        check(exp_q.size() == 0, "R6", "final queue empty", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule